// File: doc/BRIEF.md
# Hierarchical Depth Tile Culler

The culler sits in a rasterizer between scan conversion and texturing. It keeps one coarse depth record for each 4x4 pixel tile of the screen. Each incoming tile fragment carries a tile address, the nearest and furthest depth of the triangle inside that tile, and a flag that says whether the triangle covers all 16 pixels. The culler returns one of three verdicts for the whole tile:
- **reject**: the tile is hidden and is dropped.
- **accept**: the tile is in front and skips the per-pixel depth test.
- **per-pixel**: anything else, which goes on to the full-resolution depth test.

Depth values are 24 bits, and a smaller value is nearer. The coarse record is 8 bits and holds the top bits of a far bound, so it always errs toward far. A fully covering tile that is accepted writes its own quantized furthest depth into the record. A clear input resets every record to the far plane in a single cycle by invalidating a per-tile flag; the record memory itself is not swept. The verdict is registered and is returned one cycle after the request is taken. Both sides use a valid/ready handshake.

Top module: `hzc_culler`

## Requirements
- R1: After reset, out_valid is 0, in_ready is 1, and every tile record equals the far plane 8'hFF. A tile at the deepest depth 24'hFFFFFF is therefore not rejected.
- R2: A request is rejected when in_zmin[23:16] is greater than the tile's record. The reject verdict code is 2'd1.
- R3: A request is accepted when in_full is 1, the request is not rejected, and in_zmax[23:16] is less than the record. The accept verdict code is 2'd2. Equality with the record does not accept.
- R4: Every other request gets the per-pixel verdict, code 2'd0. This includes partial-coverage tiles (in_full=0) that lie entirely in front. Code 2'd3 never appears.
- R5: On an accept, the record of that tile becomes in_zmax[23:16]. Reject and per-pixel verdicts leave every record unchanged, and other tiles are never affected.
- R6: A cycle with clear=1 sets every record to 8'hFF. A request taken in that same cycle is classified against 8'hFF, and if it is accepted, its record update survives the clear.
- R7: A request is taken when in_valid and in_ready are both 1. In the next cycle, out_valid is 1, out_verdict holds its verdict and out_tile echoes its tile address. Back-to-back requests to the same tile see each other's updates.
- R8: While out_valid=1 and out_ready=0, in_ready is 0 and out_verdict and out_tile stay stable. in_ready is 1 whenever out_valid is 0 or out_ready is 1.
- R9: A request offered while in_ready is 0 is not taken. It produces no verdict and no record update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clear | input | 1 | Reset all tile records to the far plane |
| in_valid | input | 1 | Request valid |
| in_ready | output | 1 | Request can be taken |
| in_tile | input | TILE_AW | Tile address |
| in_zmin | input | ZW | Nearest depth of the fragment in the tile |
| in_zmax | input | ZW | Furthest depth of the fragment in the tile |
| in_full | input | 1 | Fragment covers all 16 pixels |
| out_valid | output | 1 | Verdict valid |
| out_ready | input | 1 | Verdict consumer ready |
| out_verdict | output | 2 | 0 per-pixel, 1 reject, 2 accept |
| out_tile | output | TILE_AW | Tile address of the verdict |

## Verification
A clear and a classification can fall in the same cycle. The bench provokes this by first lowering a tile's record, then sending, together with clear, a fully covering request to that tile. Against the old record this request would be rejected; against the far plane it is accepted. The result is judged in three ways: the accept verdict itself, a following request that is rejected only if the accept's update survived the clear, and a probe of another tile that shows the clear took effect there.

// File: rtl/hzc_pkg.sv
package hzc_pkg;
  typedef enum logic [1:0] {
    VERD_PERPIX = 2'd0,
    VERD_REJECT = 2'd1,
    VERD_ACCEPT = 2'd2
  } verdict_e;
endpackage

// File: rtl/hzc_tile_store.sv
module hzc_tile_store #(
  parameter int TILE_AW = 8,
  parameter int CW      = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               clear,
  input  logic [TILE_AW-1:0] rd_addr,
  output logic [CW-1:0]      rd_code,
  input  logic               wr_en,
  input  logic [TILE_AW-1:0] wr_addr,
  input  logic [CW-1:0]      wr_code
);
  localparam int TILES = 1 << TILE_AW;

  // Record memory: no reset, so it maps onto distributed RAM.
  logic [CW-1:0]    mem [TILES];
  // One flag per tile; a cleared flag means "record is the far plane".
  logic [TILES-1:0] live;

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_code;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      live <= '0;
    end else begin
      if (clear) live <= '0;
      // A write in the same cycle as clear takes effect after the clear.
      if (wr_en) live[wr_addr] <= 1'b1;
    end
  end

  always_comb begin
    if (clear || !live[rd_addr]) rd_code = '1;
    else                         rd_code = mem[rd_addr];
  end
endmodule

// File: rtl/hzc_classify.sv
module hzc_classify
  import hzc_pkg::*;
#(
  parameter int ZW = 24,
  parameter int CW = 8
) (
  input  logic [CW-1:0] code,
  input  logic [ZW-1:0] zmin,
  input  logic [ZW-1:0] zmax,
  input  logic          full,
  output verdict_e      verdict,
  output logic          upd,
  output logic [CW-1:0] upd_code
);
  localparam int SHIFT = ZW - CW;

  logic [ZW-1:0] far_edge;   // deepest depth the code stands for
  logic [ZW-1:0] near_edge;  // shallowest depth the code stands for
  logic          hidden;
  logic          in_front;

  assign far_edge  = {code, {SHIFT{1'b1}}};
  assign near_edge = {code, {SHIFT{1'b0}}};
  assign hidden    = zmin > far_edge;
  assign in_front  = full && (zmax < near_edge);

  always_comb begin
    if (hidden)        verdict = VERD_REJECT;
    else if (in_front) verdict = VERD_ACCEPT;
    else               verdict = VERD_PERPIX;
  end

  assign upd      = !hidden && in_front;
  assign upd_code = zmax[ZW-1:SHIFT];
endmodule

// File: rtl/hzc_out_stage.sv
module hzc_out_stage
  import hzc_pkg::*;
#(
  parameter int TILE_AW = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               take,
  input  verdict_e           verdict,
  input  logic [TILE_AW-1:0] tile,
  output logic               can_take,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [1:0]         out_verdict,
  output logic [TILE_AW-1:0] out_tile
);
  assign can_take = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid   <= 1'b0;
      out_verdict <= VERD_PERPIX;
      out_tile    <= '0;
    end else if (can_take) begin
      out_valid <= take;
      if (take) begin
        out_verdict <= verdict;
        out_tile    <= tile;
      end
    end
  end
endmodule

// File: rtl/hzc_culler.sv
module hzc_culler
  import hzc_pkg::*;
#(
  parameter int TILE_AW = 8,
  parameter int ZW      = 24,
  parameter int CW      = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               clear,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [TILE_AW-1:0] in_tile,
  input  logic [ZW-1:0]      in_zmin,
  input  logic [ZW-1:0]      in_zmax,
  input  logic               in_full,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [1:0]         out_verdict,
  output logic [TILE_AW-1:0] out_tile
);
  logic [CW-1:0] rec_code;
  logic [CW-1:0] new_code;
  logic          upd;
  logic          take;
  verdict_e      verdict;

  assign take = in_valid && in_ready;

  hzc_tile_store #(.TILE_AW(TILE_AW), .CW(CW)) u_store (
    .clk     (clk),
    .rst     (rst),
    .clear   (clear),
    .rd_addr (in_tile),
    .rd_code (rec_code),
    .wr_en   (take && upd),
    .wr_addr (in_tile),
    .wr_code (new_code)
  );

  hzc_classify #(.ZW(ZW), .CW(CW)) u_class (
    .code     (rec_code),
    .zmin     (in_zmin),
    .zmax     (in_zmax),
    .full     (in_full),
    .verdict  (verdict),
    .upd      (upd),
    .upd_code (new_code)
  );

  hzc_out_stage #(.TILE_AW(TILE_AW)) u_out (
    .clk         (clk),
    .rst         (rst),
    .take        (take),
    .verdict     (verdict),
    .tile        (in_tile),
    .can_take    (in_ready),
    .out_valid   (out_valid),
    .out_ready   (out_ready),
    .out_verdict (out_verdict),
    .out_tile    (out_tile)
  );
endmodule

// File: rtl/hzc_culler_chk.sv
module hzc_culler_chk #(
  parameter int TILE_AW = 8,
  parameter int ZW      = 24
) (
  input logic               clk,
  input logic               rst,
  input logic               clear,
  input logic               in_valid,
  input logic               in_ready,
  input logic [TILE_AW-1:0] in_tile,
  input logic [ZW-1:0]      in_zmin,
  input logic [ZW-1:0]      in_zmax,
  input logic               in_full,
  input logic               out_valid,
  input logic               out_ready,
  input logic [1:0]         out_verdict,
  input logic [TILE_AW-1:0] out_tile
);
  logic fire;
  assign fire = in_valid && in_ready;

  AST_IDLE_AFTER_RESET: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> !out_valid && in_ready); // R1

  AST_PARTIAL_NO_ACCEPT: assert property (@(posedge clk) disable iff (rst)
    fire && !in_full |=> out_verdict != 2'd2); // R4

  AST_VERDICT_LEGAL: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> out_verdict != 2'd3); // R4

  AST_CLEAR_NO_REJECT: assert property (@(posedge clk) disable iff (rst)
    fire && clear |=> out_verdict != 2'd1); // R6

  AST_FIRE_GIVES_VERDICT: assert property (@(posedge clk) disable iff (rst)
    fire |=> out_valid && out_tile == $past(in_tile)); // R7

  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_verdict) && $stable(out_tile)); // R8

  AST_STALL_BLOCKS_INPUT: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |-> !in_ready); // R9

  AST_IDLE_NO_VERDICT: assert property (@(posedge clk) disable iff (rst)
    !in_valid && in_ready |=> !out_valid); // R9
endmodule

bind hzc_culler hzc_culler_chk #(.TILE_AW(TILE_AW), .ZW(ZW)) u_chk (.*);

// File: tb/test_hzc_culler.sv
module test_hzc_culler;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        clear = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [7:0]  in_tile = '0;
  logic [23:0] in_zmin = '0;
  logic [23:0] in_zmax = '0;
  logic        in_full = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [1:0]  out_verdict;
  logic [7:0]  out_tile;

  int n_chk = 0;
  int n_bad = 0;
  logic [7:0] ref_code [256];

  hzc_culler i_hzc_culler (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [1:0] ref_verdict(input logic [7:0] c, input logic [23:0] zmin,
                                             input logic [23:0] zmax, input logic full);
    if (zmin[23:16] > c)                return 2'd1;
    else if (full && zmax[23:16] < c)   return 2'd2;
    else                                return 2'd0;
  endfunction

  // One request, taken at the next edge; verdict checked one cycle later.
  task automatic do_req(input logic [7:0] t, input logic [23:0] zmin, input logic [23:0] zmax,
                        input logic full, input logic clr, input string tag);
    logic [1:0] exp;
    if (clr) for (int i = 0; i < 256; i++) ref_code[i] = 8'hFF;
    exp = ref_verdict(ref_code[t], zmin, zmax, full);
    if (exp == 2'd2) ref_code[t] = zmax[23:16];
    @(negedge clk);
    chk(in_ready === 1'b1, {tag, " R8 ready"}, int'(in_ready), 1);
    in_valid = 1'b1; in_tile = t; in_zmin = zmin; in_zmax = zmax; in_full = full; clear = clr;
    @(negedge clk);
    in_valid = 1'b0; clear = 1'b0;
    chk(out_valid === 1'b1, {tag, " R7 valid"}, int'(out_valid), 1);
    chk(out_verdict === exp, tag, int'(out_verdict), int'(exp));
    chk(out_tile === t, {tag, " R7 tile"}, int'(out_tile), int'(t));
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk(out_valid === 1'b0, "R1 out_valid after reset", int'(out_valid), 0);
    chk(in_ready === 1'b1, "R1 in_ready after reset", int'(in_ready), 1);
    do_req(8'd5, 24'hFFFFFF, 24'hFFFFFF, 1'b1, 1'b0, "R1 far plane not rejected");
  endtask

  task automatic t_classify;
    do_req(8'd3, 24'h100000, 24'h20FFFF, 1'b1, 1'b0, "R3 accept vs far");
    do_req(8'd3, 24'h210000, 24'h220000, 1'b1, 1'b0, "R2 reject after update R5");
    do_req(8'd3, 24'h208000, 24'h300000, 1'b1, 1'b0, "R4 straddle equal code");
    do_req(8'd3, 24'h100000, 24'h1FFFFF, 1'b1, 1'b0, "R3 accept strictly in front");
    do_req(8'd3, 24'h000000, 24'h1E0000, 1'b0, 1'b0, "R4 partial in front");
    do_req(8'd3, 24'h1F0000, 24'h1F0000, 1'b1, 1'b0, "R3 equal code no accept");
    do_req(8'd3, 24'h200000, 24'h200000, 1'b0, 1'b0, "R5 record unchanged reject");
    do_req(8'd4, 24'hFFFFFF, 24'hFFFFFF, 1'b0, 1'b0, "R5 neighbour tile untouched");
  endtask

  task automatic t_clear;
    @(negedge clk); clear = 1'b1;
    @(negedge clk); clear = 1'b0;
    for (int i = 0; i < 256; i++) ref_code[i] = 8'hFF;
    chk(out_valid === 1'b0, "R9 clear alone gives no verdict", int'(out_valid), 0);
    do_req(8'd3, 24'h300000, 24'h300000, 1'b0, 1'b0, "R6 clear restores far plane");
  endtask

  task automatic t_clear_same_cycle;
    do_req(8'd7, 24'h000000, 24'h10FFFF, 1'b1, 1'b0, "R3 prepare tile 7");
    do_req(8'd3, 24'h000000, 24'h05FFFF, 1'b1, 1'b0, "R3 prepare tile 3");
    do_req(8'd7, 24'h200000, 24'h20FFFF, 1'b1, 1'b1, "R6 request with clear accepted");
    do_req(8'd7, 24'h210000, 24'h210000, 1'b1, 1'b0, "R6 update survives clear");
    do_req(8'd3, 24'hF00000, 24'hF00000, 1'b0, 1'b0, "R6 other tile cleared");
  endtask

  task automatic t_back_to_back;
    @(negedge clk);
    in_valid = 1'b1; in_tile = 8'd11; in_zmin = 24'h000000; in_zmax = 24'h40FFFF; in_full = 1'b1;
    @(negedge clk);
    chk(out_valid === 1'b1 && out_verdict === 2'd2, "R7 back-to-back first", int'(out_verdict), 2);
    in_zmin = 24'h500000; in_zmax = 24'h500000; in_full = 1'b0;
    @(negedge clk);
    in_valid = 1'b0;
    chk(out_valid === 1'b1 && out_verdict === 2'd1, "R7 back-to-back second", int'(out_verdict), 1);
    chk(out_tile === 8'd11, "R7 back-to-back tile", int'(out_tile), 11);
    ref_code[11] = 8'h40;
  endtask

  task automatic t_backpressure;
    @(negedge clk);
    out_ready = 1'b0;
    in_valid = 1'b1; in_tile = 8'd20; in_zmin = 24'h000000; in_zmax = 24'hFFFFFF; in_full = 1'b0;
    @(negedge clk);
    in_tile = 8'd9; in_zmin = 24'h000000; in_zmax = 24'h050000; in_full = 1'b1;
    for (int k = 0; k < 3; k++) begin
      chk(out_valid === 1'b1, "R8 stalled valid", int'(out_valid), 1);
      chk(out_verdict === 2'd0 && out_tile === 8'd20, "R8 stalled stable", int'(out_tile), 20);
      chk(in_ready === 1'b0, "R8 ready low on stall", int'(in_ready), 0);
      @(negedge clk);
    end
    in_valid = 1'b0; out_ready = 1'b1;
    @(negedge clk);
    chk(out_valid === 1'b0, "R9 stalled offer produced no verdict", int'(out_valid), 0);
    do_req(8'd9, 24'h060000, 24'h060000, 1'b0, 1'b0, "R9 stalled offer left no update");
  endtask

  initial begin
    for (int i = 0; i < 256; i++) ref_code[i] = 8'hFF;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_classify();
    t_clear();
    t_clear_same_cycle();
    t_back_to_back();
    t_backpressure();
    repeat (2) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual %0d cycles expected fewer", WATCHDOG);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule